// File: doc/BRIEF.md
# Receiver Idle Timeout Unit

This unit measures how long a serial receive line has stayed quiet after the last character. It consumes two strobes from neighbouring logic: a one-cycle pulse at each bit period and a one-cycle pulse when a character has been received. It counts bit periods down from a programmed value. When the count runs out it raises a sticky timeout flag. Baud generation and character assembly sit outside the unit.

Software, or a sequencer, controls the unit with two command pulses. The arm command cancels any count in progress and clears the flag. It then leaves the counter waiting, so that counting starts only with the next received character. The restart command loads the programmed value and starts counting at once, with no character needed. While a count runs, every received character reloads it. The measured interval is therefore the idle time since the most recent character. A programmed value of zero switches the unit off.

Top module: `rx_idle_timer`

## Requirements
- R1: After the synchronous reset, `timeout_flag` is 0 and `busy` is 0. The unit waits for a character before it counts.
- R2: A cycle with `cmd_arm_next` high has these results after the next edge: `busy` is 0, `timeout_flag` is 0, and the unit waits for a character. This command takes priority over `cmd_restart` and `char_rx` in the same cycle.
- R3: While the unit waits for a character, `bit_tick` pulses on their own start nothing. A `char_rx` pulse with a nonzero `timeout_val` makes `busy` 1 after that edge.
- R4: `cmd_restart` with a nonzero `timeout_val` makes `busy` 1 after that edge, with no character needed. It leaves `timeout_flag` as it was.
- R5: Take N as `timeout_val` at the time of loading. The N-th `bit_tick` cycle after the loading cycle sets `timeout_flag` to 1 and clears `busy` at the same edge. Before that tick the flag stays 0, unless it was already set.
- R6: A `char_rx` during a count reloads the counter to `timeout_val`. If `char_rx` and `bit_tick` arrive in the same cycle, the reload wins.
- R7: After expiry the flag stays 1 and `busy` stays 0 until a command arrives. `char_rx` and `bit_tick` pulses do not start a new count.
- R8: A `timeout_val` of 0 disables the unit. `char_rx` and `cmd_restart` start no count. A running count stops without setting the flag, and the unit falls back to waiting for a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| timeout_val | input | CNT_W | Timeout length in bit periods, 0 disables |
| cmd_arm_next | input | 1 | Clear flag, stop counting, wait for next character |
| cmd_restart | input | 1 | Load and start counting at once |
| timeout_flag | output | 1 | Sticky timeout indication, registered |
| busy | output | 1 | Count in progress, registered |

## Verification
The bench builds the unit with `CNT_W` = 4, so every nonzero timeout length from 1 to 15 can be swept. Each length is run with bit-tick spacings of one, two and three clocks. The bench computes the expiry tick from the loop indices and checks the flag and `busy` after every tick. The small width also keeps the directed cases short: reload, a tick that coincides with a character, command priority, and disabling a count partway through.

// File: rtl/rit_pkg.sv
package rit_pkg;
  typedef enum logic [1:0] {
    RIT_WAIT  = 2'd0,
    RIT_COUNT = 2'd1,
    RIT_DONE  = 2'd2
  } rit_state_t;
endpackage

// File: rtl/rit_counter.sv
// Down counter: it loads the programmed length and steps down on request.
module rit_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         at_one
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (dec && cnt != 0) cnt <= cnt - ONE;
  end

  assign at_one = (cnt == ONE);
endmodule

// File: rtl/rit_flag.sv
// Sticky flag: clearing takes priority over setting.
module rit_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/rit_ctrl.sv
// Sequencer: waiting, counting and expired states, plus command priority.
module rit_ctrl
  import rit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic char_rx,
  input  logic val_zero,
  input  logic cmd_arm,
  input  logic cmd_restart,
  input  logic at_one,
  output logic load,
  output logic dec,
  output logic set_flag,
  output logic clr_flag,
  output logic busy
);
  rit_state_t st, nxt;

  always_comb begin
    nxt      = st;
    load     = 1'b0;
    dec      = 1'b0;
    set_flag = 1'b0;
    clr_flag = 1'b0;
    if (cmd_arm) begin
      clr_flag = 1'b1;
      nxt      = RIT_WAIT;
    end else if (cmd_restart && !val_zero) begin
      load = 1'b1;
      nxt  = RIT_COUNT;
    end else begin
      unique case (st)
        RIT_WAIT: begin
          if (char_rx && !val_zero) begin
            load = 1'b1;
            nxt  = RIT_COUNT;
          end
        end
        RIT_COUNT: begin
          if (val_zero) begin
            nxt = RIT_WAIT;
          end else if (char_rx) begin
            load = 1'b1;
          end else if (bit_tick) begin
            if (at_one) begin
              set_flag = 1'b1;
              nxt      = RIT_DONE;
            end else begin
              dec = 1'b1;
            end
          end
        end
        RIT_DONE: nxt = RIT_DONE;
        default:  nxt = RIT_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RIT_WAIT;
      busy <= 1'b0;
    end else begin
      st   <= nxt;
      busy <= (nxt == RIT_COUNT);
    end
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             char_rx,
  input  logic [CNT_W-1:0] timeout_val,
  input  logic             cmd_arm_next,
  input  logic             cmd_restart,
  output logic             timeout_flag,
  output logic             busy
);
  logic val_zero, load, dec, set_flag, clr_flag, at_one;

  assign val_zero = (timeout_val == '0);

  rit_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .char_rx(char_rx),
    .val_zero(val_zero), .cmd_arm(cmd_arm_next), .cmd_restart(cmd_restart),
    .at_one(at_one), .load(load), .dec(dec), .set_flag(set_flag),
    .clr_flag(clr_flag), .busy(busy)
  );

  rit_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(timeout_val),
    .dec(dec), .at_one(at_one)
  );

  rit_flag u_flag (
    .clk(clk), .rst(rst), .set(set_flag), .clr(clr_flag), .q(timeout_flag)
  );
endmodule

// File: rtl/rit_checker.sv
module rit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_tick,
  input logic             char_rx,
  input logic [CNT_W-1:0] timeout_val,
  input logic             cmd_arm_next,
  input logic             cmd_restart,
  input logic             timeout_flag,
  input logic             busy
);
  // R2: the arm command stops the count and clears the flag
  a_r2_arm_clears: assert property (@(posedge clk) disable iff (rst)
    cmd_arm_next |=> (!timeout_flag && !busy));

  // R3: a waiting unit never starts counting without a character or a restart
  a_r3_no_self_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && !char_rx && !cmd_restart) |=> !busy);

  // R4: restart with a nonzero value starts counting at once
  a_r4_restart_runs: assert property (@(posedge clk) disable iff (rst)
    (cmd_restart && !cmd_arm_next && timeout_val != '0) |=> busy);

  // R5: the flag rises only on a tick that ends a running count
  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> ($past(bit_tick) && $past(busy) && !busy));

  // R6: a character during a count keeps it running
  a_r6_char_reloads: assert property (@(posedge clk) disable iff (rst)
    (busy && char_rx && !cmd_arm_next && timeout_val != '0) |=> busy);

  // R7: the flag is sticky until the arm command
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !cmd_arm_next) |=> timeout_flag);

  // R8: a zero value never leaves a count running
  a_r8_zero_off: assert property (@(posedge clk) disable iff (rst)
    (timeout_val == '0) |=> !busy);
endmodule

bind rx_idle_timer rit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .char_rx(char_rx),
  .timeout_val(timeout_val), .cmd_arm_next(cmd_arm_next),
  .cmd_restart(cmd_restart), .timeout_flag(timeout_flag), .busy(busy)
);

// File: tb/tb_rx_idle_timer.sv
module tb_rx_idle_timer;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_tick = 1'b0;
  logic         char_rx = 1'b0;
  logic [W-1:0] timeout_val = '0;
  logic         cmd_arm_next = 1'b0;
  logic         cmd_restart = 1'b0;
  logic         timeout_flag, busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rx_idle_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .char_rx(char_rx),
    .timeout_val(timeout_val), .cmd_arm_next(cmd_arm_next),
    .cmd_restart(cmd_restart), .timeout_flag(timeout_flag), .busy(busy)
  );

  // One clock: inputs and samples move 2 ns after the rising edge.
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic pulse_arm();
    cmd_arm_next = 1'b1; cyc(); cmd_arm_next = 1'b0;
  endtask
  task automatic pulse_char();
    char_rx = 1'b1; cyc(); char_rx = 1'b0;
  endtask
  task automatic pulse_restart();
    cmd_restart = 1'b1; cyc(); cmd_restart = 1'b0;
  endtask
  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 1; g < gap; g++) cyc();
      bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk("R1", "flag after reset", timeout_flag, 1'b0);
    chk("R1", "busy after reset", busy, 1'b0);

    // Sweep: every length 1..15, tick spacing 1..3
    for (int v = 1; v < 16; v++) begin
      for (int gap = 1; gap <= 3; gap++) begin
        timeout_val = W'(v);
        pulse_arm();
        chk("R2", "flag after arm", timeout_flag, 1'b0);
        chk("R2", "busy after arm", busy, 1'b0);
        ticks(3, 1);
        chk("R3", "busy after lone ticks", busy, 1'b0);
        pulse_char();
        chk("R3", "busy after char", busy, 1'b1);
        for (int k = 1; k <= v; k++) begin
          ticks(1, gap);
          chk("R5", "flag per tick", timeout_flag, (k == v));
          chk("R5", "busy per tick", busy, (k < v));
        end
        pulse_char();
        ticks(2, 1);
        chk("R7", "busy after expiry", busy, 1'b0);
        chk("R7", "flag sticky", timeout_flag, 1'b1);
      end
    end

    // R6: a character reloads the count
    timeout_val = W'(5);
    pulse_arm();
    pulse_char();
    ticks(3, 1);
    pulse_char();
    ticks(4, 1);
    chk("R6", "flag after reload+4", timeout_flag, 1'b0);
    chk("R6", "busy after reload+4", busy, 1'b1);
    ticks(1, 1);
    chk("R6", "flag after reload+5", timeout_flag, 1'b1);

    // R6: a char and a tick in the same cycle reload
    pulse_arm();
    pulse_char();
    ticks(4, 1);
    char_rx = 1'b1; bit_tick = 1'b1; cyc(); char_rx = 1'b0; bit_tick = 1'b0;
    chk("R6", "flag after tie", timeout_flag, 1'b0);
    ticks(4, 2);
    chk("R6", "flag 4 after tie", timeout_flag, 1'b0);
    ticks(1, 2);
    chk("R6", "flag 5 after tie", timeout_flag, 1'b1);

    // R4: restart starts without a character and keeps the flag
    timeout_val = W'(3);
    pulse_restart();
    chk("R4", "busy on restart, flag set", busy, 1'b1);
    chk("R4", "flag kept on restart", timeout_flag, 1'b1);
    pulse_arm();
    pulse_restart();
    chk("R4", "busy on restart", busy, 1'b1);
    ticks(2, 1);
    chk("R4", "flag at 2 of 3", timeout_flag, 1'b0);
    ticks(1, 1);
    chk("R4", "flag at 3 of 3", timeout_flag, 1'b1);

    // R2: arm wins over restart and char together
    cmd_arm_next = 1'b1; cmd_restart = 1'b1; char_rx = 1'b1;
    cyc();
    cmd_arm_next = 1'b0; cmd_restart = 1'b0; char_rx = 1'b0;
    chk("R2", "busy under priority", busy, 1'b0);
    chk("R2", "flag under priority", timeout_flag, 1'b0);

    // R8: value zero disables
    timeout_val = '0;
    pulse_char();
    chk("R8", "char with zero", busy, 1'b0);
    pulse_restart();
    chk("R8", "restart with zero", busy, 1'b0);
    timeout_val = W'(6);
    pulse_char();
    chk("R8", "busy before disable", busy, 1'b1);
    timeout_val = '0;
    cyc();
    chk("R8", "busy after disable", busy, 1'b0);
    timeout_val = W'(6);
    ticks(10, 1);
    chk("R8", "no flag after disable", timeout_flag, 1'b0);
    chk("R8", "waits after disable", busy, 1'b0);
    pulse_char();
    chk("R8", "char restarts after disable", busy, 1'b1);

    // R1: reset during a count
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R1", "busy after mid reset", busy, 1'b0);
    ticks(8, 1);
    chk("R1", "no flag after mid reset", timeout_flag, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule